// File: doc/BRIEF.md
# Multi-queue interprocessor mailbox controller

The controller lets several processors exchange 32-bit messages through a small set of hardware message queues, all reached through one 32-bit register port. Each queue has a message word, a full flag and an occupancy count. Writing the message word pushes a message into the queue. Reading it pops the oldest message.

Every queue raises two events: one when a message arrives and one when the queue stops being full. Each event is posted into the status register of every user. A user picks the events it cares about with its own enable register and sees them on its own interrupt output. The user acknowledges an event by writing a one to its status bit.

A compile-time switch selects between two register layouts:
- In the first layout, the enable register is replaced by a plain write.
- In the second layout, enable bits are set and cleared through separate write-one words.

Top module: `mbx_ctrl`

## Requirements
- R1: The word at byte offset 0x000 reads 8'h{major,minor}, with the major revision in bits [7:4] and the minor revision in bits [3:0]. The defaults are 2 and 1, so the word reads 0x21. Every word not mapped in the active layout reads zero. Writes to read-only or unmapped words change nothing.
- R2: Queue m has its message word at byte 0x040+4*m. A write pushes the data. A read pops and returns messages in first-in first-out order. Each queue holds 4 entries.
- R3: A push to a full queue is dropped. A read from an empty queue returns the message most recently popped from that queue (zero since reset) and leaves the queue unchanged.
- R4: The word at 0x080+4*m reads 1 while queue m holds 4 messages, and 0 otherwise.
- R5: The word at 0x0C0+4*m reads the number of messages held in queue m.
- R6: Each accepted push into queue m sets status bit 2*m in every user's status register.
- R7: A pop that takes queue m from full to not full sets status bit 2*m+1 in every user's status register.
- R8: Writing ones to a status word clears those bits. Zero bits are left as they are. A later read shows the cleared value.
- R9: In the first layout, user u has its status at 0x100+8*u and its enable at 0x104+8*u. A write to the enable word replaces the whole enable value.
- R10: In the second layout, user u has its status at 0x104+0x10*u, an enable-set word at 0x108+0x10*u and an enable-clear word at 0x10C+0x10*u. Writing a one to a bit of the set word sets that enable bit. Writing a one to a bit of the clear word clears it. Both words read back the current enable value.
- R11: Interrupt output u is high exactly when some bit is set in both the status and the enable register of user u.
- R12: After reset:
  - all queues are empty;
  - all status and enable bits are zero;
  - every interrupt output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe, one access per cycle |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | ADDR_W | Byte address; bits [1:0] are ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the read strobe |
| irq_o | output | NUM_USERS | Per-user interrupt request |

## Verification
The bench drives both layouts through a fill-past-full and drain-past-empty sequence on every queue, followed by a long pseudo-random mix of accesses. Every read and every interrupt level is compared against an arithmetic model.

The sequences target specific faults:
- A design that accepts a fifth push would show a count of 5 or a stale head.
- A design that pops an empty queue would return zero instead of the last message.
- A design that raises the not-full event on every pop, instead of only on the pop that leaves the full state, would set status bits the model keeps clear.
- A design that decodes the enable-clear word as a plain write would wipe enable bits that should stay set.
- A design that ignored the one-bits of a status write would keep the interrupt high after acknowledge.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  // Word indices (byte offset / 4) of the per-user interrupt registers.
  function automatic int unsigned stat_word(bit alt, int unsigned u);
    return alt ? (32'h41 + 4 * u) : (32'h40 + 2 * u);
  endfunction

  function automatic int unsigned en_word(bit alt, int unsigned u);
    return alt ? (32'h42 + 4 * u) : (32'h41 + 2 * u);
  endfunction

  function automatic int unsigned clr_word(int unsigned u);
    return 32'h43 + 4 * u;
  endfunction

  localparam int unsigned MSG_BASE_W  = 16;  // 0x040
  localparam int unsigned FULL_BASE_W = 32;  // 0x080
  localparam int unsigned CNT_BASE_W  = 48;  // 0x0C0
endpackage

// File: rtl/mbx_queue.sv
module mbx_queue #(
  parameter int DEPTH = 4,
  parameter int W     = 32,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [W-1:0]  wdata_i,
  output logic [W-1:0]  head_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          left_full_o
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_q, wr_n, rd_q, rd_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [W-1:0]  last_q, last_n;
  logic          do_push, do_pop, empty;

  assign empty   = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign do_push = push_i & ~full_o;
  assign do_pop  = pop_i & ~empty;

  function automatic logic [PW-1:0] inc(logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wr_n   = wr_q;
    rd_n   = rd_q;
    cnt_n  = cnt_q;
    last_n = last_q;
    if (do_push) begin
      wr_n  = inc(wr_q);
      cnt_n = cnt_q + 1'b1;
    end
    if (do_pop) begin
      rd_n   = inc(rd_q);
      cnt_n  = cnt_q - 1'b1;
      last_n = mem[rd_q];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= '0;
      rd_q   <= '0;
      cnt_q  <= '0;
      last_q <= '0;
    end else begin
      wr_q   <= wr_n;
      rd_q   <= rd_n;
      cnt_q  <= cnt_n;
      last_q <= last_n;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= wdata_i;
  end

  assign head_o      = empty ? last_q : mem[rd_q];
  assign count_o     = cnt_q;
  assign left_full_o = do_pop & full_o;

  p_drop_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    push_i && full_o && !pop_i |=> count_o == CW'(DEPTH));
  p_empty_pop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i && empty && !push_i |=> count_o == '0 && $stable(head_o));
  p_count_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    count_o <= CW'(DEPTH));
endmodule

// File: rtl/mbx_user.sv
module mbx_user #(
  parameter int NB = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NB-1:0] ev_i,
  input  logic          st_w1c_i,
  input  logic          en_wr_i,
  input  logic          en_set_i,
  input  logic          en_clr_i,
  input  logic [NB-1:0] wdata_i,
  output logic [NB-1:0] status_o,
  output logic [NB-1:0] enable_o,
  output logic          irq_o
);
  logic [NB-1:0] st_q, st_n, en_q, en_n;

  always_comb begin
    st_n = (st_q & ~(st_w1c_i ? wdata_i : '0)) | ev_i;
    en_n = en_q;
    if (en_wr_i)       en_n = wdata_i;
    else if (en_set_i) en_n = en_q | wdata_i;
    else if (en_clr_i) en_n = en_q & ~wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= '0;
      en_q <= '0;
    end else begin
      st_q <= st_n;
      en_q <= en_n;
    end
  end

  assign status_o = st_q;
  assign enable_o = en_q;
  assign irq_o    = |(st_q & en_q);

  p_event_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    |ev_i |=> (status_o & $past(ev_i)) == $past(ev_i));
  p_w1c_r8: assert property (@(posedge clk) disable iff (!rst_n)
    st_w1c_i && ev_i == '0 |=> (status_o & $past(wdata_i)) == '0);
  p_en_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    en_clr_i |=> (enable_o & $past(wdata_i)) == '0);
  p_en_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    en_set_i |=> (enable_o & $past(wdata_i)) == $past(wdata_i));
endmodule

// File: rtl/mbx_ctrl.sv
module mbx_ctrl #(
  parameter int       NUM_QUEUES  = 4,
  parameter int       NUM_USERS   = 3,
  parameter int       DEPTH       = 4,
  parameter bit       ALT_LAYOUT  = 1'b0,
  parameter int       ADDR_W      = 9,
  parameter bit [3:0] REV_MAJOR   = 4'h2,
  parameter bit [3:0] REV_MINOR   = 4'h1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_sel,
  input  logic                 bus_wr,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  output logic [NUM_USERS-1:0] irq_o
);
  import mbx_pkg::*;

  localparam int NB   = 2 * NUM_QUEUES;
  localparam int CW   = $clog2(DEPTH + 1);
  localparam int WI_W = ADDR_W - 2;

  logic [WI_W-1:0] wi;
  logic            unused_addr;
  assign wi          = bus_addr[ADDR_W-1:2];
  assign unused_addr = ^bus_addr[1:0];

  logic [NUM_QUEUES-1:0]          push, pop, full, left_full;
  logic [NUM_QUEUES-1:0][31:0]    head;
  logic [NUM_QUEUES-1:0][CW-1:0]  cnt;
  logic [NB-1:0]                  ev;
  logic [NUM_USERS-1:0][NB-1:0]   st_all, en_all;
  logic [31:0]                    rd_n, rd_q;

  for (genvar q = 0; q < NUM_QUEUES; q++) begin : g_q
    assign push[q] = bus_sel &  bus_wr & (wi == WI_W'(MSG_BASE_W + q));
    assign pop[q]  = bus_sel & ~bus_wr & (wi == WI_W'(MSG_BASE_W + q));
    mbx_queue #(.DEPTH(DEPTH), .W(32)) u_queue (
      .clk(clk), .rst_n(rst_n), .push_i(push[q]), .pop_i(pop[q]),
      .wdata_i(bus_wdata), .head_o(head[q]), .count_o(cnt[q]),
      .full_o(full[q]), .left_full_o(left_full[q]));
    assign ev[2*q]   = push[q] & ~full[q];
    assign ev[2*q+1] = left_full[q];
  end

  for (genvar u = 0; u < NUM_USERS; u++) begin : g_u
    logic st_w1c, en_wr, en_set, en_clr;
    assign st_w1c = bus_sel & bus_wr & (wi == WI_W'(stat_word(ALT_LAYOUT, u)));
    if (ALT_LAYOUT) begin : g_alt
      assign en_wr  = 1'b0;
      assign en_set = bus_sel & bus_wr & (wi == WI_W'(en_word(1'b1, u)));
      assign en_clr = bus_sel & bus_wr & (wi == WI_W'(clr_word(u)));
    end else begin : g_leg
      assign en_wr  = bus_sel & bus_wr & (wi == WI_W'(en_word(1'b0, u)));
      assign en_set = 1'b0;
      assign en_clr = 1'b0;
    end
    mbx_user #(.NB(NB)) u_user (
      .clk(clk), .rst_n(rst_n), .ev_i(ev), .st_w1c_i(st_w1c),
      .en_wr_i(en_wr), .en_set_i(en_set), .en_clr_i(en_clr),
      .wdata_i(bus_wdata[NB-1:0]), .status_o(st_all[u]),
      .enable_o(en_all[u]), .irq_o(irq_o[u]));
  end

  always_comb begin
    rd_n = '0;
    if (wi == '0) rd_n = {24'b0, REV_MAJOR, REV_MINOR};
    for (int q = 0; q < NUM_QUEUES; q++) begin
      if (wi == WI_W'(MSG_BASE_W + q))  rd_n = head[q];
      if (wi == WI_W'(FULL_BASE_W + q)) rd_n = {31'b0, full[q]};
      if (wi == WI_W'(CNT_BASE_W + q))  rd_n = 32'(cnt[q]);
    end
    for (int u = 0; u < NUM_USERS; u++) begin
      if (wi == WI_W'(stat_word(ALT_LAYOUT, u))) rd_n = 32'(st_all[u]);
      if (wi == WI_W'(en_word(ALT_LAYOUT, u)))   rd_n = 32'(en_all[u]);
      if (ALT_LAYOUT && wi == WI_W'(clr_word(u))) rd_n = 32'(en_all[u]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                rd_q <= '0;
    else if (bus_sel && !bus_wr) rd_q <= rd_n;
  end

  assign bus_rdata = rd_q;

  p_one_event_kind_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(push & ~full) + $countones(left_full) <= 1);
  p_irq_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_sel |=> $stable(irq_o));
endmodule

// File: tb/mbx_ctrl_test.sv
module mbx_ctrl_test;
  timeunit 1ns; timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel_l = 1'b0, sel_a = 1'b0, bus_wr = 1'b0;
  logic [8:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rdata_l, rdata_a;
  logic [2:0]  irq_l, irq_a;

  always #2 clk = ~clk;

  mbx_ctrl #(.ALT_LAYOUT(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel_l), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_l), .irq_o(irq_l));
  mbx_ctrl #(.ALT_LAYOUT(1'b1)) uut_alt (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel_a), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_a), .irq_o(irq_a));

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  logic [31:0] mq [4][4];
  int          mrd [4];
  int          mcnt [4];
  logic [31:0] mlast [4];
  logic [7:0]  mst [3];
  logic [7:0]  men [3];
  logic [31:0] rng = 32'h1234_5678;

  task automatic chk(string tag, int w, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s word %0d: actual %h expected %h", tag, w, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int q = 0; q < 4; q++) begin mrd[q] = 0; mcnt[q] = 0; mlast[q] = '0; end
    for (int u = 0; u < 3; u++) begin mst[u] = '0; men[u] = '0; end
  endtask

  task automatic model(input bit alt, input bit wr, input int w, input logic [31:0] d,
                       output logic [31:0] exp, output string tag);
    exp = '0; tag = "R1";
    if (w == 0) exp = 32'h21;
    else if (w >= 16 && w < 20) begin
      int q = w - 16;
      if (wr) begin
        if (mcnt[q] < 4) begin
          mq[q][(mrd[q] + mcnt[q]) % 4] = d;
          mcnt[q]++;
          for (int u = 0; u < 3; u++) mst[u][2*q] = 1'b1;
        end
      end else if (mcnt[q] == 0) begin
        exp = mlast[q]; tag = "R3";
      end else begin
        exp = mq[q][mrd[q]]; mlast[q] = exp; tag = "R2";
        if (mcnt[q] == 4) for (int u = 0; u < 3; u++) mst[u][2*q+1] = 1'b1;
        mrd[q] = (mrd[q] + 1) % 4; mcnt[q]--;
      end
    end
    else if (w >= 32 && w < 36) begin exp = (mcnt[w-32] == 4) ? 1 : 0; tag = "R4"; end
    else if (w >= 48 && w < 52) begin exp = mcnt[w-48]; tag = "R5"; end
    else begin
      for (int u = 0; u < 3; u++) begin
        if (w == (alt ? 65 + 4*u : 64 + 2*u)) begin
          exp = 32'(mst[u]); tag = "R6 R7 R8";
          if (wr) mst[u] = mst[u] & ~d[7:0];
        end
        if (w == (alt ? 66 + 4*u : 65 + 2*u)) begin
          exp = 32'(men[u]); tag = alt ? "R10" : "R9";
          if (wr) men[u] = alt ? (men[u] | d[7:0]) : d[7:0];
        end
        if (alt && w == 67 + 4*u) begin
          exp = 32'(men[u]); tag = "R10";
          if (wr) men[u] = men[u] & ~d[7:0];
        end
      end
    end
  endtask

  task automatic acc(input bit alt, input bit wr, input int w, input logic [31:0] d);
    logic [31:0] exp, act;
    logic [2:0]  eirq;
    string tag;
    model(alt, wr, w, d, exp, tag);
    @(negedge clk);
    sel_l = !alt; sel_a = alt; bus_wr = wr; bus_addr = 9'(w * 4); bus_wdata = d;
    @(negedge clk);
    sel_l = 1'b0; sel_a = 1'b0; bus_wr = 1'b0;
    act = alt ? rdata_a : rdata_l;
    if (!wr) chk(tag, w, act, exp);
    for (int u = 0; u < 3; u++) eirq[u] = |(mst[u] & men[u]);
    chk("R11", w, 32'(alt ? irq_a : irq_l), 32'(eirq));
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    chk("R12", -1, 32'(irq_l), 32'd0);
    chk("R12", -1, 32'(irq_a), 32'd0);
  endtask

  task automatic sweep(input bit alt);
    int span = alt ? 76 : 72;
    for (int w = 0; w < span + 4; w++) acc(alt, 1'b0, w, '0);
  endtask

  task automatic run_layout(input bit alt);
    do_reset();
    sweep(alt);                                  // R12 / R1 reset contents
    for (int w = 0; w < 80; w++)                 // R1: writes to read-only words
      if (!(w >= 16 && w < 20) && w < 64) acc(alt, 1'b1, w, 32'hFFFF_FFFF);
    sweep(alt);
    for (int u = 0; u < 3; u++) acc(alt, 1'b1, alt ? 66 + 4*u : 65 + 2*u, 32'hFF);
    for (int q = 0; q < 4; q++)                  // R2/R3: fill past full
      for (int i = 0; i < 5; i++) acc(alt, 1'b1, 16 + q, 32'hA000_0000 + 32'h1000 * q + i);
    sweep(alt);
    for (int q = 0; q < 4; q++)                  // R2/R3/R7: drain past empty
      for (int i = 0; i < 6; i++) acc(alt, 1'b0, 16 + q, '0);
    sweep(alt);
    for (int u = 0; u < 3; u++) begin            // R8 partial acknowledge
      acc(alt, 1'b1, alt ? 65 + 4*u : 64 + 2*u, 32'h55);
      acc(alt, 1'b0, alt ? 65 + 4*u : 64 + 2*u, '0);
      acc(alt, 1'b1, alt ? 65 + 4*u : 64 + 2*u, 32'hAA);
    end
    if (alt) acc(1'b1, 1'b1, 71, 32'h0F);        // R10 clear word, user 1
    else     acc(1'b0, 1'b1, 67, 32'h0F);        // R9 replace, user 1
    sweep(alt);
    for (int n = 0; n < 3000; n++) begin
      int w, k;
      rng ^= rng << 13; rng ^= rng >> 17; rng ^= rng << 5;
      k = int'(rng[3:0]);
      if (k < 6)       w = 16 + int'(rng[5:4]);
      else if (k < 8)  w = 32 + int'(rng[5:4]);
      else if (k < 10) w = 48 + int'(rng[5:4]);
      else if (k < 14) w = 64 + int'(rng[7:4]) % 12;
      else             w = int'(rng[12:6]) % 80;
      acc(alt, rng[16], w, {rng[31:8], rng[7:0] ^ rng[23:16]});
    end
  endtask

  initial begin
    repeat (2) @(negedge clk);
    run_layout(1'b0);
    run_layout(1'b1);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule